// File: doc/BRIEF.md
# Multi-Pair I2S Receive Controller

This block captures audio from up to four stereo pairs that share one serial bit clock and one word-select line, each pair arriving on its own serial data line. The bit clock and word-select come from elsewhere and are oversampled by the system clock. On each bit clock rising edge the block shifts in every active data line. It frames words at word-select transitions, with the MSB one bit clock after the transition. It keeps as many leading bits as the pair's resolution asks for, and stores each completed left/right pair as one entry in that pair's own receive FIFO.

Software or a DMA engine reads samples through a small memory-mapped register space. Each pair has its own enable, resolution, FIFO threshold, status and interrupt mask. A single interrupt line reports unmasked data-available and overrun conditions from all pairs. A shared DMA read port drains pair 0 as a left, right, left, right stream. A global flush empties every receive FIFO at once.

Top module: `i2s_rx_multi`

## Requirements
- R1: After reset, the global enable, the receive enable and all pair enables read 0. Every resolution register reads 5, every mask reads 3 and every threshold reads 0. Every status reads 0, `irq` is low, and buffer reads return 0.
- R2: Words are captured into a pair only while bit 0 of the global enable (0x000), bit 0 of the receive enable (0x004) and bit 0 of that pair's enable (0x028 + 0x40*p) are all 1. With any of them at 0, that pair's FIFO does not fill.
- R3: A word belongs to the left channel while word-select is 0 and to the right channel while it is 1. The MSB is sampled on the bit clock rise after the transition, and the last bit is sampled on the rise where word-select changes again. An entry is stored only when a right word completes after a captured left word. The first transition after enabling only aligns the framing.
- R4: The resolution register (0x030 + 0x40*p) accepts code 2 (16 bits), 4 (24 bits) or 5 (32 bits). A write of any other code leaves it unchanged. The first N received bits of a word are returned right-justified, with the upper bits zero.
- R5: Reading the left buffer (0x020 + 0x40*p) returns the oldest entry's left sample without removing it. Reading the right buffer (0x024 + 0x40*p) returns its right sample and removes the entry. Either read returns 0 when the FIFO is empty.
- R6: Each pair's FIFO holds 8 entries. A pair completed while the FIFO is full is discarded, and status bit 1 (overrun) is set.
- R7: Status bit 0 (0x038 + 0x40*p) is 1 exactly when the fill level is greater than the 3-bit threshold (0x048 + 0x40*p), so threshold 7 signals only a full FIFO.
- R8: Any read or write of a pair's overrun-clear offset (0x040 + 0x40*p) clears that pair's overrun flag.
- R9: Writing 1 to bit 0 of 0x014 empties every pair's FIFO in one cycle and leaves overrun flags unchanged.
- R10: `irq` is high when any pair has a status bit set whose mask bit (bits 1:0 of 0x03C + 0x40*p, bit 1 for overrun, bit 0 for data-available) is 0.
- R11: Successive reads of 0x1C0 return pair 0's oldest left sample, then its right sample, which removes the entry, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops and clear-on-access act on it) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bclk | input | 1 | Serial bit clock, oversampled by `clk` |
| lrclk | input | 1 | Word-select, 0 = left, 1 = right |
| sdin | input | NPAIR | One serial data line per pair |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
Several properties are checked on every cycle:
- No FIFO count ever exceeds its depth.
- An overrun flag only rises when the FIFO was full the cycle before.
- A flush leaves every FIFO empty on the next cycle.
- The resolution registers only ever hold a legal code.
- A pair that is not running never gains entries.

Only the bench scenarios can show the rest:
- The bit framing and the truncation at each resolution.
- The non-popping left read.
- The threshold boundary.
- That the overflowing word, and only it, is lost.
- The clear-on-access and DMA ordering.

// File: rtl/i2s_rx_multi.sv
module i2s_rx_multi #(
  parameter int NPAIR = 4,
  parameter int DEPTH = 8,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             bclk,
  input  logic             lrclk,
  input  logic [NPAIR-1:0] sdin,
  output logic             irq
);
  localparam int PW = $clog2(NPAIR);
  localparam int DW = $clog2(DEPTH);
  localparam logic [DW:0]   FULL    = (DW+1)'(DEPTH);
  localparam logic [AW-1:0] A_GEN   = AW'('h000);
  localparam logic [AW-1:0] A_RXEN  = AW'('h004);
  localparam logic [AW-1:0] A_FLUSH = AW'('h014);
  localparam logic [AW-1:0] A_BASE  = AW'('h020);
  localparam logic [AW-1:0] A_DMA   = AW'('h1C0);
  localparam logic [5:0] O_LEFT = 6'h00, O_RIGHT = 6'h04, O_EN = 6'h08, O_RES = 6'h10;
  localparam logic [5:0] O_STAT = 6'h18, O_MASK = 6'h1C, O_OVC = 6'h20, O_THR = 6'h28;

  logic gen_en, rx_en, synced, bclk_q, ws_q, dma_hi;
  logic [5:0] bitcnt;
  logic [NPAIR-1:0] pen, lvalid, ovr, push, pop;
  logic [2:0]    rcode [NPAIR];
  logic [1:0]    msk   [NPAIR];
  logic [1:0]    stat  [NPAIR];
  logic [DW-1:0] thr   [NPAIR];
  logic [DW-1:0] wp    [NPAIR];
  logic [DW-1:0] rp    [NPAIR];
  logic [DW:0]   cnt   [NPAIR];
  logic [31:0]   sh    [NPAIR];
  logic [31:0]   lhold [NPAIR];
  logic [31:0]   word  [NPAIR];
  logic [63:0]   mem   [NPAIR][DEPTH];

  wire run      = gen_en & rx_en;
  wire rise     = bclk & ~bclk_q;
  wire edge_ws  = rise & (lrclk != ws_q);
  wire flush    = bus_wr && bus_addr == A_FLUSH && bus_wdata[0];
  wire [AW-1:0] rel = bus_addr - A_BASE;
  wire [PW-1:0] psel = rel[PW+5:6];
  wire [5:0] off = rel[5:0];
  wire in_pair = bus_addr >= A_BASE && (rel >> 6) < AW'(NPAIR);

  function automatic logic [5:0] wbits(input logic [2:0] c);
    case (c)
      3'd2:    return 6'd16;
      3'd4:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  always_comb begin
    irq = 1'b0;
    for (int p = 0; p < NPAIR; p++) begin
      word[p] = (bitcnt < wbits(rcode[p])) ? {sh[p][30:0], sdin[p]} : sh[p];
      push[p] = run & pen[p] & synced & edge_ws & ws_q & lvalid[p];
      pop[p]  = cnt[p] != '0 && bus_rd &&
                ((in_pair && psel == PW'(p) && off == O_RIGHT) ||
                 (p == 0 && bus_addr == A_DMA && dma_hi));
      stat[p] = {ovr[p], cnt[p] > {1'b0, thr[p]}};
      irq     = irq | (|(stat[p] & ~msk[p]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_GEN) bus_rdata[0] = gen_en;
    else if (bus_addr == A_RXEN) bus_rdata[0] = rx_en;
    else if (bus_addr == A_DMA) begin
      if (cnt[0] != '0) bus_rdata = dma_hi ? mem[0][rp[0]][31:0] : mem[0][rp[0]][63:32];
    end else if (in_pair) begin
      case (off)
        O_LEFT:  if (cnt[psel] != '0) bus_rdata = mem[psel][rp[psel]][63:32];
        O_RIGHT: if (cnt[psel] != '0) bus_rdata = mem[psel][rp[psel]][31:0];
        O_EN:    bus_rdata[0]    = pen[psel];
        O_RES:   bus_rdata[2:0]  = rcode[psel];
        O_STAT:  bus_rdata[1:0]  = stat[psel];
        O_MASK:  bus_rdata[1:0]  = msk[psel];
        O_THR:   bus_rdata[DW-1:0] = thr[psel];
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0; rx_en <= 1'b0; synced <= 1'b0; bclk_q <= 1'b0;
      ws_q <= 1'b0; dma_hi <= 1'b0; bitcnt <= '0;
      pen <= '0; lvalid <= '0; ovr <= '0;
      for (int p = 0; p < NPAIR; p++) begin
        rcode[p] <= 3'd5; msk[p] <= 2'b11; thr[p] <= '0;
        wp[p] <= '0; rp[p] <= '0; cnt[p] <= '0; sh[p] <= '0; lhold[p] <= '0;
      end
    end else begin
      bclk_q <= bclk;
      if (rise) ws_q <= lrclk;
      if (!run) begin synced <= 1'b0; bitcnt <= '0; end
      else if (edge_ws) begin synced <= 1'b1; bitcnt <= '0; end
      else if (rise && bitcnt != 6'd63) bitcnt <= bitcnt + 6'd1;
      if (bus_wr && bus_addr == A_GEN)  gen_en <= bus_wdata[0];
      if (bus_wr && bus_addr == A_RXEN) rx_en  <= bus_wdata[0];
      if (flush) dma_hi <= 1'b0;
      else if (bus_rd && bus_addr == A_DMA && cnt[0] != '0) dma_hi <= ~dma_hi;
      for (int p = 0; p < NPAIR; p++) begin
        if (in_pair && psel == PW'(p) && off == O_OVC && (bus_wr || bus_rd)) ovr[p] <= 1'b0;
        if (bus_wr && in_pair && psel == PW'(p)) begin
          case (off)
            O_EN:    pen[p] <= bus_wdata[0];
            O_RES:   if (bus_wdata[2:0] inside {3'd2, 3'd4, 3'd5}) rcode[p] <= bus_wdata[2:0];
            O_MASK:  msk[p] <= bus_wdata[1:0];
            O_THR:   thr[p] <= bus_wdata[DW-1:0];
            default: ;
          endcase
        end
        if (!(run && pen[p])) begin
          sh[p] <= '0; lvalid[p] <= 1'b0;
        end else if (edge_ws) begin
          sh[p] <= '0;
          if (ws_q) lvalid[p] <= 1'b0;
          else if (synced) begin lhold[p] <= word[p]; lvalid[p] <= 1'b1; end
        end else if (rise && bitcnt < wbits(rcode[p])) sh[p] <= word[p];
        if (flush) begin
          wp[p] <= '0; rp[p] <= '0; cnt[p] <= '0;
        end else begin
          if (push[p] && cnt[p] == FULL) ovr[p] <= 1'b1;
          if (push[p] && cnt[p] != FULL) wp[p] <= wp[p] + DW'(1);
          if (pop[p]) rp[p] <= rp[p] + DW'(1);
          cnt[p] <= cnt[p] + (DW+1)'(push[p] && cnt[p] != FULL) - (DW+1)'(pop[p]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPAIR; p++)
      if (!flush && push[p] && cnt[p] != FULL) mem[p][wp[p]] <= {lhold[p], word[p]};
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_chk
    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= FULL);
    assert_ovr_from_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr[g]) |-> $past(cnt[g]) == FULL);
    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt[g] == '0);
    assert_res_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rcode[g] == 3'd2 || rcode[g] == 3'd4 || rcode[g] == 3'd5);
    assert_no_fill_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && pen[g]) |=> cnt[g] <= $past(cnt[g]));
  end
endmodule

// File: tb/i2s_rx_multi_tb.sv
module i2s_rx_multi_tb;
  localparam int CLK_P = 10;
  localparam int NP = 4;
  localparam int AW = 9;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, bclk = 0, lrclk = 1, irq;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] sdin = '0, prev_lsb = '0;
  int total = 0, bad = 0;
  bit mid_left = 0;

  i2s_rx_multi #(.NPAIR(NP), .DEPTH(8), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bclk(bclk), .lrclk(lrclk),
    .sdin(sdin), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  localparam logic [75:0] VEC [6] = '{
    {4'h5, 8'd32, 32'hA5A5_1234, 32'h0F0F_8001},
    {4'h2, 8'd16, 32'hBEEF_1111, 32'h8001_FFFF},
    {4'h4, 8'd24, 32'h1234_5678, 32'hFEDC_BA98},
    {4'h5, 8'd32, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'h2, 8'd16, 32'h0001_0000, 32'hFFFF_0000},
    {4'h4, 8'd24, 32'h8000_00FF, 32'h0000_0100}};

  function automatic logic [AW-1:0] pa(input int p, input int off);
    return AW'(32 + 64 * p + off);
  endfunction
  function automatic logic [31:0] fv(input int k, input int p, input int side);
    return {8'(p), 8'(k), 8'(side), 8'h5A};
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #(CLK_P/4) d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rchk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic bit_period(input logic wsv, input logic [NP-1:0] b);
    @(negedge clk); bclk = 0; lrclk = wsv; sdin = b;
    @(negedge clk);
    @(negedge clk); bclk = 1;
    @(negedge clk);
  endtask

  task automatic send_slot(input logic wsv, input logic [NP-1:0][31:0] w, input int start);
    for (int i = start; i < 32; i++) begin
      logic [NP-1:0] b;
      for (int p = 0; p < NP; p++) b[p] = (i == 0) ? prev_lsb[p] : w[p][32-i];
      bit_period(wsv, b);
    end
    for (int p = 0; p < NP; p++) prev_lsb[p] = w[p][0];
  endtask

  task automatic send_frame(input logic [NP-1:0][31:0] l, input logic [NP-1:0][31:0] r);
    send_slot(1'b0, l, mid_left ? 1 : 0);
    send_slot(1'b1, r, 0);
    mid_left = 0;
  endtask

  task automatic send_end();
    bit_period(1'b0, prev_lsb);
    mid_left = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frames(input int n, input int base);
    for (int k = 0; k < n; k++) begin
      logic [NP-1:0][31:0] l, r;
      for (int p = 0; p < NP; p++) begin l[p] = fv(base + k, p, 1); r[p] = fv(base + k, p, 2); end
      send_frame(l, r);
    end
    send_end();
  endtask

  task automatic resync();
    send_frames(1, 99);
    wr(AW'('h014), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements) got=timeout exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rchk("R1 global enable", AW'('h000), 0);
    rchk("R1 rx enable", AW'('h004), 0);
    rchk("R1 pair enable", pa(1, 8), 0);
    rchk("R1 resolution", pa(2, 16), 5);
    rchk("R1 mask", pa(3, 28), 3);
    rchk("R1 threshold", pa(0, 40), 0);
    rchk("R1 status", pa(0, 24), 0);
    rchk("R1 empty left R5", pa(0, 0), 0);
    chk("R1 irq", 32'(irq), 0);

    wr(AW'('h000), 1); wr(AW'('h004), 1);
    for (int p = 0; p < NP; p++) wr(pa(p, 8), 1);
    resync();

    // R3 R4 table of resolutions and bit patterns
    foreach (VEC[i]) begin
      logic [NP-1:0][31:0] l, r;
      int bits;
      bits = int'(VEC[i][71:64]);
      for (int p = 0; p < NP; p++) begin
        wr(pa(p, 16), 32'(VEC[i][75:72]));
        l[p] = VEC[i][63:32] ^ (32'(p) << 28);
        r[p] = VEC[i][31:0] ^ (32'(p) << 28);
      end
      send_frame(l, r);
      send_end();
      for (int p = 0; p < NP; p++) begin
        rchk("R3 R4 left sample", pa(p, 0), l[p] >> (32 - bits));
        rchk("R3 R4 right sample", pa(p, 4), r[p] >> (32 - bits));
      end
      rchk("R5 empty after pop", pa(2, 0), 0);
    end

    // R4 illegal codes ignored (last table code was 4)
    wr(pa(1, 16), 3);
    rchk("R4 code 3 ignored", pa(1, 16), 4);
    wr(pa(1, 16), 7);
    rchk("R4 code 7 ignored", pa(1, 16), 4);
    for (int p = 0; p < NP; p++) wr(pa(p, 16), 5);

    // R5 left read does not pop
    send_frames(1, 1);
    rchk("R5 left peek 1", pa(1, 0), fv(1, 1, 1));
    rchk("R5 left peek 2", pa(1, 0), fv(1, 1, 1));
    rchk("R5 avail before pop R7", pa(1, 24), 1);
    rchk("R5 right pops", pa(1, 4), fv(1, 1, 2));
    rchk("R5 avail after pop", pa(1, 24), 0);
    wr(AW'('h014), 1);

    // R7 threshold boundary
    wr(pa(0, 40), 2);
    send_frames(2, 10);
    rchk("R7 fill 2 thr 2", pa(0, 24), 0);
    send_frames(1, 12);
    rchk("R7 fill 3 thr 2", pa(0, 24), 1);
    wr(AW'('h014), 1);
    rchk("R9 flushed status", pa(0, 24), 0);
    rchk("R9 flushed left", pa(0, 0), 0);

    // R6 R10 overrun
    wr(pa(0, 40), 7);
    wr(pa(0, 28), 0);
    send_frames(8, 20);
    rchk("R6 R7 full no overrun", pa(0, 24), 1);
    chk("R10 irq on avail", 32'(irq), 1);
    send_frames(1, 28);
    rchk("R6 overrun set", pa(0, 24), 3);
    rchk("R6 first kept", pa(0, 0), fv(20, 0, 1));
    for (int k = 0; k < 7; k++) begin
      logic [31:0] d;
      rd(pa(0, 4), d);
    end
    rchk("R6 eighth kept", pa(0, 4), fv(27, 0, 2));
    rchk("R6 ninth dropped", pa(0, 0), 0);
    rchk("R6 overrun persists", pa(0, 24), 2);
    chk("R10 irq on overrun", 32'(irq), 1);
    wr(pa(0, 28), 2);
    chk("R10 irq masked", 32'(irq), 0);
    wr(pa(0, 32), 0);
    rchk("R8 write clears", pa(0, 24), 0);
    begin
      logic [31:0] d;
      rd(pa(3, 32), d);
    end
    rchk("R8 read clears", pa(3, 24), 1);
    wr(AW'('h014), 1);
    rchk("R9 flush keeps overrun", pa(2, 24), 2);
    for (int p = 0; p < NP; p++) wr(pa(p, 32), 0);

    // R11 DMA order
    wr(pa(0, 40), 0);
    send_frames(2, 40);
    rchk("R11 dma l0", AW'('h1C0), fv(40, 0, 1));
    rchk("R11 dma r0", AW'('h1C0), fv(40, 0, 2));
    rchk("R11 dma l1", AW'('h1C0), fv(41, 0, 1));
    rchk("R11 dma r1", AW'('h1C0), fv(41, 0, 2));
    rchk("R11 dma drained", pa(0, 24), 0);

    // R2 gating
    wr(AW'('h014), 1);
    wr(pa(1, 8), 0);
    send_frames(1, 50);
    rchk("R2 pair disabled", pa(1, 24), 0);
    rchk("R2 pair disabled left", pa(1, 0), 0);
    rchk("R2 other pair runs", pa(0, 24), 1);
    wr(AW'('h014), 1);
    wr(AW'('h000), 0);
    send_frames(2, 60);
    rchk("R2 global off", pa(0, 24), 0);
    wr(AW'('h000), 1);
    wr(AW'('h004), 0);
    send_frames(2, 70);
    rchk("R2 rx off", pa(2, 24), 0);

    summary();
  end
endmodule